// File: doc/BRIEF.md
# Multiword DMA Strobe Sequencer

This block is the host-side timing engine for a parallel-ATA multiword DMA burst. Once the device raises its DMA request and the host has enabled a transfer, the sequencer asserts the active-low DMA acknowledge. It then issues one read or one write strobe per data word, each with a fixed active phase and a recovery phase. Both phases are counted in cycles of the system clock. Five timing modes are available. Each one fixes the minimum strobe-low time, the minimum strobe-high time and the minimum time from one strobe to the next. The block lengthens the recovery phase until the sum of the two phases reaches the full cycle minimum.

Write words come from the host through a valid/ready handshake. Each word is driven onto the data bus when its strobe asserts, and it stays there through recovery. Read words are captured in the last active cycle, on the edge where the strobe negates, and are handed to the host with a one-cycle valid pulse. A burst stops after the current word once the word count runs out or the request is found low. The acknowledge is always held for the whole recovery phase after the last strobe.

Top module: `mdma_seq`

## Requirements
- R1: While reset is asserted and right after it, dmack_no, iord_no and iowr_no are high, and dd_oe_o, busy_o, rvalid_o and wready_o are low.
- R2: A burst starts only from idle, and only when en_i and dmarq_i are both high and cnt_i is non-zero. dmack_no goes low on the next clock edge and busy_o is high while the acknowledge is held. If en_i is low, or cnt_i is zero, dmack_no stays high.
- R3: Each strobe stays low for exactly A cycles of the 10 ns clock. A is 22, 8, 7, 7 and 6 for mode_i codes 0 to 4. Codes 5 to 7 use the mode-0 timing.
- R4: Between two strobes of a burst, and with no write stall, the strobe stays high for exactly R cycles. R is 26, 7, 5, 3 and 2 for modes 0 to 4, so the full word cycle is 48, 15, 12, 10 and 8 cycles. A stall can make the gap longer but never shorter.
- R5: In a read burst (wr_i = 0), only iord_no pulses. rdata_o shows dd_i as sampled in the last low cycle of the strobe, and rvalid_o is high for exactly the one cycle in which iord_no has just returned high.
- R6: In a write burst (wr_i = 1), only iowr_no pulses. A word is taken when wvalid_i and wready_o are both high, in word order. It appears on dd_o with dd_oe_o high while the strobe is low, and it stays there through the rising strobe edge. While no word is offered, the next strobe waits.
- R7: A burst of cnt_i words produces exactly cnt_i strobes. dmack_no rises exactly R cycles after the last strobe negates, and R is never less than the acknowledge hold of 2 cycles in mode 0 and 1 cycle in the other modes.
- R8: When dmarq_i is sampled low at the end of a recovery phase, the burst ends after the word already transferred, even if words remain.
- R9: mode_i is latched when the burst starts. Changes to mode_i during the burst do not alter any phase length.
- R10: iord_no and iowr_no are never low at the same time, and neither is low while dmack_no is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, 10 ns period by default |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Host allows a burst to start |
| wr_i | input | 1 | Burst direction: 1 write, 0 read |
| mode_i | input | 3 | Timing mode code |
| cnt_i | input | 16 | Number of words in the burst |
| dmarq_i | input | 1 | Device DMA request, active high |
| dmack_no | output | 1 | DMA acknowledge, active low |
| iord_no | output | 1 | Read strobe, active low |
| iowr_no | output | 1 | Write strobe, active low |
| dd_i | input | 16 | Data bus from the device |
| dd_o | output | 16 | Data bus to the device |
| dd_oe_o | output | 1 | Output enable for dd_o |
| wdata_i | input | 16 | Write word from the host |
| wvalid_i | input | 1 | Write word offered |
| wready_o | output | 1 | Write word taken on this edge if offered |
| rdata_o | output | 16 | Read word to the host |
| rvalid_o | output | 1 | Read word valid pulse |
| busy_o | output | 1 | Burst in progress |

## Verification
The assertions check every cycle that the strobes are mutually exclusive and covered by the acknowledge. They also check that no active phase, recovery phase, full cycle or acknowledge hold falls short of the minimum for the mode latched at burst start, and that the read valid pulse lines up with a read strobe negation. Exact phase lengths are left to the bench scenarios. So are word ordering and write data integrity, read capture against a device model that changes its data on every strobe, and the word counts that result from early request drop or count exhaustion. Stalled write streams with mid-burst mode changes are also covered only there.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int NUM_MODES = 5;
  localparam int TW = 8;

  typedef logic [TW-1:0] tcnt_t;

  typedef struct packed {
    tcnt_t act;
    tcnt_t rec;
  } mdma_tim_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACT, ST_REC} mdma_st_t;

  function automatic int fold_mode(int m);
    return (m >= NUM_MODES) ? 0 : m;
  endfunction

  function automatic int ns_cycle(int m);
    case (fold_mode(m))
      1: return 150; 2: return 120; 3: return 100; 4: return 80;
      default: return 480;
    endcase
  endfunction

  function automatic int ns_active(int m);
    case (fold_mode(m))
      1: return 80; 2: return 70; 3: return 65; 4: return 55;
      default: return 215;
    endcase
  endfunction

  function automatic int ns_recover(int m);
    case (fold_mode(m))
      2, 3: return 25; 4: return 20;
      default: return 50;
    endcase
  endfunction

  function automatic int ns_setup(int m);
    case (fold_mode(m))
      1: return 30; 2: return 20; 3: return 15; 4: return 10;
      default: return 100;
    endcase
  endfunction

  function automatic int ns_whold(int m);
    case (fold_mode(m))
      1: return 15; 2: return 10; 3, 4: return 5;
      default: return 20;
    endcase
  endfunction

  function automatic int ns_ackhold(int m);
    return (fold_mode(m) == 0) ? 20 : 5;
  endfunction

  function automatic int to_clk(int ns, int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cycle_clk(int m, int clk_ns);
    return to_clk(ns_cycle(m), clk_ns);
  endfunction

  function automatic int ackhold_clk(int m, int clk_ns);
    return to_clk(ns_ackhold(m), clk_ns);
  endfunction

  // recovery absorbs whatever the total cycle still needs
  function automatic mdma_tim_t mode_timing(int m, int clk_ns);
    mdma_tim_t t;
    int a, r;
    a = imax(to_clk(ns_active(m), clk_ns), to_clk(ns_setup(m), clk_ns));
    r = imax(to_clk(ns_recover(m), clk_ns), cycle_clk(m, clk_ns) - a);
    r = imax(r, imax(to_clk(ns_whold(m), clk_ns), ackhold_clk(m, clk_ns)));
    t.act = tcnt_t'(a);
    t.rec = tcnt_t'(r);
    return t;
  endfunction
endpackage

// File: rtl/mdma_timing.sv
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int MW     = 3
) (
  input  logic [MW-1:0] mode_i,
  output mdma_tim_t     tim_o
);
  localparam int ENTRIES = 1 << MW;

  mdma_tim_t tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_mode
    assign tab[g] = mode_timing(g, CLK_NS);
  end

  assign tim_o = tab[mode_i];
endmodule

// File: rtl/mdma_phase_timer.sv
module mdma_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int MW     = 3,
  parameter int DW     = 16,
  parameter int CW     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [MW-1:0] mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dmarq_i,
  output logic          dmack_no,
  output logic          iord_no,
  output logic          iowr_no,
  input  logic [DW-1:0] dd_i,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic [DW-1:0] wdata_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
  ,output logic         busy_o
);
  localparam logic [CW-1:0] CONE = CW'(1);
  localparam tcnt_t TONE = tcnt_t'(1);

  mdma_st_t      st_q, st_d;
  logic [MW-1:0] mode_q;
  logic          wr_q;
  logic [CW-1:0] rem_q;
  logic          dmack_nq, iord_nq, iowr_nq, oe_q, rvalid_q;
  logic [DW-1:0] dd_q, rdata_q;
  mdma_tim_t     tim;
  logic          t_zero, t_load, go, start, launch;
  tcnt_t         t_val;

  mdma_timing #(.CLK_NS(CLK_NS), .MW(MW)) u_tim (
    .mode_i (mode_q),
    .tim_o  (tim)
  );

  mdma_phase_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  assign start  = en_i && dmarq_i && (cnt_i != '0);
  assign launch = !wr_q || wvalid_i;

  always_comb begin
    st_d   = st_q;
    go     = 1'b0;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_WAIT;
      ST_WAIT: begin
        if (!dmarq_i)    st_d = ST_IDLE;
        else if (launch) go = 1'b1;
      end
      ST_ACT: if (t_zero) begin
        st_d   = ST_REC;
        t_load = 1'b1;
        t_val  = tim.rec - TONE;
      end
      ST_REC: if (t_zero) begin
        if (rem_q == '0 || !dmarq_i) st_d = ST_IDLE;
        else if (launch)             go = 1'b1;
        else                         st_d = ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
    if (go) begin
      st_d   = ST_ACT;
      t_load = 1'b1;
      t_val  = tim.act - TONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= '0;
      wr_q     <= 1'b0;
      rem_q    <= '0;
      dmack_nq <= 1'b1;
      iord_nq  <= 1'b1;
      iowr_nq  <= 1'b1;
      oe_q     <= 1'b0;
      dd_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rvalid_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          mode_q   <= mode_i;
          wr_q     <= wr_i;
          rem_q    <= cnt_i;
          dmack_nq <= 1'b0;
        end
        ST_ACT: if (t_zero) begin
          iord_nq <= 1'b1;
          iowr_nq <= 1'b1;
          rem_q   <= rem_q - CONE;
          if (!wr_q) begin
            rdata_q  <= dd_i;  // captured on the negating edge
            rvalid_q <= 1'b1;
          end
        end
        default: ;
      endcase
      if (go) begin
        iord_nq <= wr_q;
        iowr_nq <= !wr_q;
        if (wr_q) begin
          dd_q <= wdata_i;
          oe_q <= 1'b1;
        end
      end
      if (st_d == ST_IDLE && st_q != ST_IDLE) begin
        dmack_nq <= 1'b1;
        oe_q     <= 1'b0;
      end
    end
  end

  assign wready_o = wr_q && dmarq_i &&
                    (st_q == ST_WAIT || (st_q == ST_REC && t_zero && rem_q != '0));
  assign dmack_no = dmack_nq;
  assign iord_no  = iord_nq;
  assign iowr_no  = iowr_nq;
  assign dd_o     = dd_q;
  assign dd_oe_o  = oe_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/mdma_seq_chk.sv
module mdma_seq_chk
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int MW     = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [MW-1:0] mode_i,
  input logic          dmack_no,
  input logic          iord_no,
  input logic          iowr_no,
  input logic          dd_oe_o,
  input logic          rvalid_o
);
  logic          strb_n, strb_q, seen;
  logic [MW-1:0] mode_l;
  tcnt_t         lo_cnt, hi_cnt, lo_last;
  tcnt_t         act_l, rec_l, cyc_l, hold_l;
  mdma_tim_t     tim_l;

  assign strb_n = iord_no & iowr_no;

  always_comb begin
    tim_l  = mode_timing(int'(mode_l), CLK_NS);
    act_l  = tim_l.act;
    rec_l  = tim_l.rec;
    cyc_l  = tcnt_t'(cycle_clk(int'(mode_l), CLK_NS));
    hold_l = tcnt_t'(ackhold_clk(int'(mode_l), CLK_NS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q  <= 1'b1;
      seen    <= 1'b0;
      mode_l  <= '0;
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      lo_last <= '0;
    end else begin
      strb_q <= strb_n;
      if (dmack_no) mode_l <= mode_i;
      if (dmack_no)     seen <= 1'b0;
      else if (!strb_n) seen <= 1'b1;
      if (strb_n) begin
        lo_cnt <= '0;
        hi_cnt <= (hi_cnt != '1) ? hi_cnt + tcnt_t'(1) : hi_cnt;
      end else begin
        hi_cnt <= '0;
        lo_cnt <= (lo_cnt != '1) ? lo_cnt + tcnt_t'(1) : lo_cnt;
      end
      if (strb_n && !strb_q) lo_last <= lo_cnt;
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!iord_no && !iowr_no));
  p_strobe_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strb_n |-> !dmack_no);
  p_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_n && !strb_q) |-> (lo_cnt >= act_l));
  p_recovery_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_n && strb_q && seen) |-> (hi_cnt >= rec_l));
  p_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_n && strb_q && seen) |-> ({1'b0, lo_last} + {1'b0, hi_cnt} >= {1'b0, cyc_l}));
  p_ack_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dmack_no) && seen) |-> (hi_cnt >= hold_l));
  p_oe_in_burst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dd_oe_o |-> !dmack_no);
  p_rvalid_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $rose(iord_no));
endmodule

bind mdma_seq mdma_seq_chk #(.CLK_NS(CLK_NS), .MW(MW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .dmack_no (dmack_no),
  .iord_no  (iord_no),
  .iowr_no  (iowr_no),
  .dd_oe_o  (dd_oe_o),
  .rvalid_o (rvalid_o)
);

// File: tb/mdma_seq_test.sv
module mdma_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en_i = 1'b0, wr_i = 1'b0, dmarq_i = 1'b0, wvalid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [15:0] cnt_i = '0, dd_i = '0, wdata_i = '0;
  logic        dmack_no, iord_no, iowr_no, dd_oe_o, wready_o, rvalid_o, busy_o;
  logic [15:0] dd_o, rdata_o;

  mdma_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en_i), .wr_i(wr_i), .mode_i(mode_i),
    .cnt_i(cnt_i), .dmarq_i(dmarq_i), .dmack_no(dmack_no), .iord_no(iord_no),
    .iowr_no(iowr_no), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o),
    .wdata_i(wdata_i), .wvalid_i(wvalid_i), .wready_o(wready_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o), .busy_o(busy_o)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit timeout = 0;
  int cur_mode = 0, drop_at = 0, nwords = 0, lo_len = 0, hi_len = 0, lo_last = 0;
  bit cur_wr = 0, stall = 0, prev_s = 1, prev_ack = 1, took = 0;
  logic [15:0] exp_rd = '0;
  logic [15:0] wq[$];

  function automatic int exp_act(int m);
    case (m)
      1: return 8; 2: return 7; 3: return 7; 4: return 6;
      default: return 22;
    endcase
  endfunction

  function automatic int exp_rec(int m);
    case (m)
      1: return 7; 2: return 5; 3: return 3; 4: return 2;
      default: return 26;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit s;
    cyc++;
    if (cyc > LIMIT) timeout = 1;
    s = iord_no & iowr_no;
    if (rst_n) begin
      // R7: acknowledge hold after last strobe
      if (dmack_no && !prev_ack && nwords > 0) begin
        chk(hi_len >= exp_rec(cur_mode), "R7 ack hold min", hi_len, exp_rec(cur_mode));
        if (!stall) chk(hi_len == exp_rec(cur_mode), "R7 ack hold", hi_len, exp_rec(cur_mode));
      end
      if (!s) begin
        if (prev_s) begin
          nwords++;
          chk(cur_wr ? (!iowr_no && iord_no) : (!iord_no && iowr_no), "R10 direction",
              {iord_no, iowr_no}, cur_wr ? 2 : 1);
          chk(!dmack_no, "R10 strobe under ack", dmack_no, 0);
          if (nwords > 1) begin
            chk(hi_len >= exp_rec(cur_mode), "R4 recovery min", hi_len, exp_rec(cur_mode));
            if (!stall) begin
              chk(hi_len == exp_rec(cur_mode), "R4 recovery", hi_len, exp_rec(cur_mode));
              chk(lo_last + hi_len == exp_act(cur_mode) + exp_rec(cur_mode), "R4 cycle",
                  lo_last + hi_len, exp_act(cur_mode) + exp_rec(cur_mode));
            end
          end
          lo_len = 1;
          if (!iord_no) begin
            dd_i = 16'($urandom);
            exp_rd = dd_i;
          end
          if (drop_at != 0 && nwords == drop_at) dmarq_i = 1'b0;
        end else lo_len++;
      end else begin
        if (!prev_s) begin
          chk(lo_len == exp_act(cur_mode), "R3 active width", lo_len, exp_act(cur_mode));
          lo_last = lo_len;
          hi_len = 1;
          if (cur_wr) begin
            chk(dd_oe_o == 1'b1, "R6 output enable", dd_oe_o, 1);
            if (wq.size() == 0) chk(0, "R6 word underrun", 0, 1);
            else begin
              logic [15:0] e;
              e = wq.pop_front();
              chk(dd_o == e, "R6 write data", dd_o, e);
            end
          end
        end else hi_len++;
      end
      if (rvalid_o) begin
        chk(!cur_wr, "R5 rvalid in write burst", 1, 0);
        chk(rdata_o == exp_rd, "R5 read data", rdata_o, exp_rd);
      end
      // host write stream
      if (took) begin
        took = 0;
        wvalid_i = stall ? ($urandom % 3 != 0) : 1'b1;
        wdata_i = 16'($urandom);
      end else if (!wvalid_i && cur_wr) wvalid_i = ($urandom % 2 == 0);
      if (wvalid_i && wready_o) begin
        wq.push_back(wdata_i);
        took = 1;
      end
    end
    prev_s = s;
    prev_ack = dmack_no;
  end

  task automatic burst(input int m, input bit wr, input int n, input int drop, input bit stl);
    int expw;
    @(negedge clk);
    wq.delete();
    cur_mode = (m > 4) ? 0 : m;
    cur_wr = wr; stall = stl; drop_at = drop; nwords = 0;
    mode_i = 3'(m); wr_i = wr; cnt_i = 16'(n); en_i = 1'b1; dmarq_i = 1'b1;
    wvalid_i = 1'b1; wdata_i = 16'($urandom);
    while (dmack_no && !timeout) @(negedge clk);
    en_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy", busy_o, 1);
    // R9: scramble mode while the burst runs
    while (!dmack_no && !timeout) begin
      @(negedge clk);
      mode_i = 3'($urandom);
    end
    expw = (drop != 0 && drop < n) ? drop : n;
    chk(nwords == expw, (drop != 0 && drop < n) ? "R8 words at drop" : "R7 word count",
        nwords, expw);
    chk(busy_o == 1'b0, "R2 idle after burst", busy_o, 0);
    dmarq_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({dmack_no, iord_no, iowr_no} == 3'b111 && !dd_oe_o && !busy_o && !rvalid_o && !wready_o,
        "R1 in reset", {dmack_no, iord_no, iowr_no}, 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({dmack_no, iord_no, iowr_no} == 3'b111 && !busy_o, "R1 after reset",
        {dmack_no, iord_no, iowr_no}, 7);

    // R2: no start without enable or with zero count
    dmarq_i = 1'b1; en_i = 1'b0; cnt_i = 16'd4;
    ok = 1;
    repeat (20) begin @(negedge clk); if (!dmack_no) ok = 0; end
    chk(ok, "R2 enable low", ok, 1);
    en_i = 1'b1; cnt_i = '0;
    ok = 1;
    repeat (20) begin @(negedge clk); if (!dmack_no) ok = 0; end
    chk(ok, "R2 zero count", ok, 1);
    en_i = 1'b0; dmarq_i = 1'b0;
    repeat (2) @(negedge clk);

    for (int m = 0; m < 5; m++) burst(m, 1'b0, 4, 0, 1'b0);
    for (int m = 0; m < 5; m++) burst(m, 1'b1, 3, 0, 1'b0);
    burst(2, 1'b0, 6, 2, 1'b0);
    burst(4, 1'b1, 5, 3, 1'b0);
    burst(1, 1'b1, 4, 0, 1'b1);
    burst(3, 1'b0, 1, 0, 1'b0);
    burst(6, 1'b0, 2, 0, 1'b0);
    burst(4, 1'b1, 1, 1, 1'b0);
    for (int i = 0; i < 24; i++) begin
      int m, n, d;
      bit w;
      m = int'($urandom % 8);
      w = ($urandom % 2 == 1);
      n = 1 + int'($urandom % 6);
      d = ($urandom % 4 == 0) ? 1 + int'($urandom % n) : 0;
      burst(m, w, n, d, w && ($urandom % 2 == 1));
      if (timeout) break;
    end
    if (timeout) chk(0, "watchdog expired", cyc, LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule